// File: doc/BRIEF.md
# Binary Lookahead Tree Adder

This block adds two unsigned words and a carry-in. The result is returned one clock later as a sum word and a carry-out. Inside, the carries come from a binary tree of lookahead cells that is walked twice. The first walk runs from the bit leaves toward the root and merges pairs of neighbouring groups into larger groups. Each merge yields a group generate and a group propagate. The second walk starts at the root from the carry-in and runs back out toward the leaves. On the way, each cell reuses the group terms it formed on the first walk to hand a carry to its upper half.

The leaves form the bit propagate as an OR of the operand bits, not an XOR. That term is correct for carry logic but cannot be used to form the sum. The sum bits are therefore built from a separate bitwise XOR combined with the carry into each bit.

The width must be a power of two, and any other width stops elaboration. Each extra tree level doubles the width. The carry path is two logic levels per tree level. The result is held in output registers with a synchronous active-high reset.

Top module: `lat_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `sum_q` and `c_out_q` are 0 after that edge.
- R2: With `rst` low, `sum_q` after a rising edge equals (`a_in` + `b_in` + `c_in`) mod 2^W, where the inputs are those sampled at that edge.
- R3: With `rst` low, `c_out_q` after a rising edge is bit W of the (W+1)-bit sum `a_in` + `b_in` + `c_in` sampled at that edge.
- R4: All-ones plus zero with carry-in 1 gives a sum of 0 and a carry-out of 1. The carry-in must cross every level of the tree on the return walk.
- R5: All-ones plus all-ones with carry-in 0 gives a sum of all ones except bit 0, and a carry-out of 1. Every bit generates.
- R6: When the operands are bitwise complements (every bit propagates and none generates), the sum is all ones with carry-out 0 when carry-in is 0. The sum is 0 with carry-out 1 when carry-in is 1.
- R7: A carry that leaves the lower half of the word enters the upper half. For example, low half all ones plus 1 gives 2^(W/2).
- R8: Zero plus zero with carry-in 1 gives a sum of 1 and a carry-out of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| c_in | input | 1 | Carry-in |
| sum_q | output | W | Registered sum |
| c_out_q | output | 1 | Registered carry-out |

## Verification
The properties assume the operands and carry-in are 0 or 1 on every bit at each rising edge once reset is released. They also assume reset is asserted from time zero. The bench holds reset high from the first instant. It changes inputs only on falling edges, so every sampled value is a defined constant. Results are compared to a widened integer sum. The stimulus covers random words, all-ones, zero, alternating-bit and half-word boundary patterns, each with both carry-in values.

// File: rtl/lat_pkg.sv
package lat_pkg;
  // Generate / propagate pair carried through the tree.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction
endpackage

// File: rtl/lat_leaf.sv
module lat_leaf #(
  parameter int W = 32
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output lat_pkg::gp_t [W-1:0] gp,
  output logic [W-1:0]         hx
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign gp[i].g = a[i] & b[i];
      assign gp[i].p = a[i] | b[i];
      assign hx[i]   = a[i] ^ b[i];
    end
  endgenerate
endmodule

// File: rtl/lat_cell.sv
module lat_cell (
  input  lat_pkg::gp_t hi,
  input  lat_pkg::gp_t lo,
  input  logic         c_lo,
  output lat_pkg::gp_t grp,
  output logic         c_hi
);
  // First walk: merge the two halves.
  assign grp  = lat_pkg::gp_merge(hi, lo);
  // Second walk: the carry into the upper half uses the lower half's terms.
  assign c_hi = lo.g | (lo.p & c_lo);
endmodule

// File: rtl/lat_tree.sv
module lat_tree #(
  parameter int W = 32
) (
  input  lat_pkg::gp_t [W-1:0] leaf,
  input  logic                 cin,
  output logic [W-1:0]         cbit,
  output logic                 cout
);
  localparam int LVL   = $clog2(W);
  localparam int NODES = 2 * W;

  // Heap numbering: node 1 is the root, children of n are 2n (low) and 2n+1 (high),
  // bit i lives at leaf node W+i.
  lat_pkg::gp_t nd_gp [1:NODES-1];
  logic         nd_c  [1:NODES-1];

  genvar n, i;
  generate
    if ((1 << LVL) != W || W < 2) begin : g_bad_width
      $error("lat_tree: width must be a power of two of at least 2");
    end

    for (i = 0; i < W; i++) begin : g_leaf
      assign nd_gp[W+i] = leaf[i];
      assign cbit[i]    = nd_c[W+i];
    end

    for (n = 1; n < W; n++) begin : g_node
      lat_cell u_cell (
        .hi   (nd_gp[2*n+1]),
        .lo   (nd_gp[2*n]),
        .c_lo (nd_c[n]),
        .grp  (nd_gp[n]),
        .c_hi (nd_c[2*n+1])
      );
      // The lower half inherits the carry entering this group.
      assign nd_c[2*n] = nd_c[n];
    end
  endgenerate

  assign nd_c[1] = cin;
  assign cout    = nd_gp[1].g | (nd_gp[1].p & cin);
endmodule

// File: rtl/lat_adder.sv
module lat_adder #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] sum_q,
  output logic         c_out_q
);
  lat_pkg::gp_t [W-1:0] leaf_gp;
  logic [W-1:0]         half_x;
  logic [W-1:0]         c_bit;
  logic                 c_top;

  lat_leaf #(.W(W)) u_leaf (
    .a  (a_in),
    .b  (b_in),
    .gp (leaf_gp),
    .hx (half_x)
  );

  lat_tree #(.W(W)) u_tree (
    .leaf (leaf_gp),
    .cin  (c_in),
    .cbit (c_bit),
    .cout (c_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      c_out_q <= 1'b0;
    end else begin
      sum_q   <= half_x ^ c_bit;
      c_out_q <= c_top;
    end
  end
endmodule

// File: rtl/lat_adder_chk.sv
module lat_adder_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         c_in,
  input logic [W-1:0] sum_q,
  input logic         c_out_q
);
  localparam logic [W-1:0] ONES = '1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !c_out_q));

  // R2
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum_q == W'({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + (W+1)'($past(c_in))));

  // R3
  carry_value_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> c_out_q == ({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + (W+1)'($past(c_in))) >> W);

  // R4
  full_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (a_in == ONES && b_in == '0 && c_in) |=> (sum_q == '0 && c_out_q));

  // R5
  all_gen_chk: assert property (@(posedge clk) disable iff (rst)
    (a_in == ONES && b_in == ONES && !c_in) |=> (sum_q == (ONES << 1) && c_out_q));

  // R6
  all_prop_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_in ^ b_in) == ONES && !c_in) |=> (sum_q == ONES && !c_out_q));
endmodule

bind lat_adder lat_adder_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_in    (a_in),
  .b_in    (b_in),
  .c_in    (c_in),
  .sum_q   (sum_q),
  .c_out_q (c_out_q)
);

// File: tb/sim_lat_adder.sv
`timescale 1ns/1ps
module sim_lat_adder;
  localparam int W = 32;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         c_in = 1'b0;
  logic [W-1:0] sum_q;
  logic         c_out_q;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  lat_adder #(.W(W)) u0 (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .c_in    (c_in),
    .sum_q   (sum_q),
    .c_out_q (c_out_q)
  );

  task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge (one register stage).
  task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci, input string req);
    logic [W:0] ref_sum;
    @(negedge clk);
    a_in = a; b_in = b; c_in = ci;
    ref_sum = {1'b0, a} + {1'b0, b} + (W+1)'(ci);
    @(negedge clk);
    check({c_out_q, sum_q} == ref_sum, req, {c_out_q, sum_q}, ref_sum);
  endtask

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] r = '0;
    for (int k = 0; k < W; k += 32) r = (r << 32) | W'($urandom);
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    a_in = ONES; b_in = ONES; c_in = 1'b1;
    @(negedge clk);
    check(sum_q == '0 && !c_out_q, "R1", {c_out_q, sum_q}, '0);
    @(negedge clk);
    check(sum_q == '0 && !c_out_q, "R1", {c_out_q, sum_q}, '0);
    rst = 1'b0;
  endtask

  task automatic t_chain();
    run_vec(ONES, '0, 1'b1, "R4");
    run_vec('0, ONES, 1'b1, "R4");
  endtask

  task automatic t_generate();
    run_vec(ONES, ONES, 1'b0, "R5");
    run_vec(ONES, ONES, 1'b1, "R5");
  endtask

  task automatic t_alternate();
    logic [W-1:0] alt;
    for (int k = 0; k < W; k++) alt[k] = k[0];
    run_vec(alt, ~alt, 1'b0, "R6");
    run_vec(alt, ~alt, 1'b1, "R6");
    run_vec(~alt, alt, 1'b0, "R6");
    run_vec(alt, alt, 1'b0, "R2");
    run_vec(alt, alt, 1'b1, "R3");
  endtask

  task automatic t_half();
    logic [W-1:0] lo_ones;
    lo_ones = ONES >> (W/2);
    run_vec(lo_ones, W'(1), 1'b0, "R7");
    run_vec(lo_ones, '0, 1'b1, "R7");
    run_vec(lo_ones << (W/4), W'(1) << (W/4), 1'b0, "R7");
  endtask

  task automatic t_zero();
    run_vec('0, '0, 1'b1, "R8");
    run_vec('0, '0, 1'b0, "R2");
  endtask

  task automatic t_random();
    for (int k = 0; k < 200; k++)
      run_vec(rand_word(), rand_word(), k[0], "R2 R3");
  endtask

  task automatic t_reset_mid();
    // Reset in the middle of traffic clears the registered result again.
    @(negedge clk);
    a_in = ONES; b_in = ONES; c_in = 1'b1; rst = 1'b1;
    @(negedge clk);
    check(sum_q == '0 && !c_out_q, "R1", {c_out_q, sum_q}, '0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_zero();
    t_chain();
    t_generate();
    t_alternate();
    t_half();
    t_random();
    t_reset_mid();
    run_vec(ONES, W'(1), 1'b0, "R3");
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule